// File: doc/BRIEF.md
# Partitioned SIMD Saturating Adder

This block adds two 64-bit operands as a packed vector of independent integer lanes. One carry chain runs across eight byte slices, and a lane-width select cuts that chain so that it forms eight 8-bit lanes, four 16-bit lanes, two 32-bit lanes or a single 64-bit lane. Each lane either wraps modulo its width or clamps to the limit it has just passed. A separate select sets whether a lane is read as signed or unsigned, and that choice fixes which limits apply.

The adder is combinational. A parameter adds one output register stage, which is on by default. Beside the packed result the block gives one saturation flag per byte position. A lane that clamps raises the flag on every byte it covers. Media kernels use it for clipping work such as audio sample mixing or pixel brightening. These kernels issue a lane-width and behaviour select together with each pair of operands.

Top module: `simd_sat_adder`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `result` and `sat_flags` become all zeros on that edge.
- R2: `lane_mode` encodes lane width as 0 = 8 bits, 1 = 16 bits, 2 = 32 bits, 3 = one 64-bit lane. Lane k covers bits [k*W+W-1 : k*W]. No carry passes from one lane into the next, and the carry into every lane is zero.
- R3: With `sat_en` low, each lane of `result` is (a_lane + b_lane) mod 2^W.
- R4: With `sat_en` high and `signed_en` low, a lane whose unsigned sum exceeds 2^W-1 yields all ones.
- R5: With `sat_en` and `signed_en` high, a lane whose operands have equal signs and whose sum has the other sign yields 2^(W-1)-1 when the operands are non-negative. It yields -2^(W-1) when they are negative.
- R6: `sat_flags` bit i belongs to byte i. It is 1 exactly when the lane containing byte i clamped, so every byte of a clamped lane shows 1. With `sat_en` low all flags are 0.
- R7: With `sat_en` high, a lane that does not overflow yields the same value as in wrapping mode.
- R8: With the default `REG_OUT` = 1, the outputs reflect the inputs sampled at the previous rising edge, one cycle of latency. Between edges the outputs hold.
- R9: With `sat_en` low, `signed_en` has no effect on `result` or `sat_flags`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Synchronous active-low reset |
| op_a | input | 64 | First packed operand |
| op_b | input | 64 | Second packed operand |
| lane_mode | input | 2 | Lane width select (0: 8, 1: 16, 2: 32, 3: 64 bits) |
| sat_en | input | 1 | 1 = saturating lanes, 0 = wrapping lanes |
| signed_en | input | 1 | 1 = signed lane limits, 0 = unsigned |
| result | output | 64 | Packed lane sums |
| sat_flags | output | 8 | Per-byte clamp flags, replicated across each lane |

## Verification
Two functions can act in the same cycle: one lane clamps while the lane next to it must receive no carry from the overflowing lane and must return its plain sum. The bench provokes this with operands built byte by byte from values near the limits (0x7F, 0x80, 0xFF, 0x00, 0x01), mixed with random bytes, in all four lane widths and all behaviour selects. A reference function computes every lane separately, and each result and flag vector is judged against it one clock after the inputs are applied.

// File: rtl/simd_add_pkg.sv
// Package: shared types and sizing helpers for the partitioned adder.
// Assumes the lane width is a power-of-two multiple of one slice.
package simd_add_pkg;

    // Lane width select; the value is log2 of the slices per lane.
    typedef enum logic [1:0] {
        LANE_B8  = 2'd0,
        LANE_B16 = 2'd1,
        LANE_B32 = 2'd2,
        LANE_B64 = 2'd3
    } lane_mode_e;

endpackage

// File: rtl/simd_lane_ctrl.sv
// Lane control: turns the lane width select into per-slice boundary
// information, i.e. whether a slice opens a lane and which slice is the
// most significant one of its lane.
// Assumes NSLICE is a power of two and at least 2^(largest mode).
module simd_lane_ctrl
    import simd_add_pkg::*;
#(
    parameter int NSLICE = 8,
    localparam int IDX_W = $clog2(NSLICE)
)(
    input  lane_mode_e                     mode,
    output logic [NSLICE-1:0]              first_slice,
    output logic [NSLICE-1:0][IDX_W-1:0]   top_idx
);

    logic [IDX_W-1:0] span;

    // Purpose: slices per lane minus one, as an index mask.
    always_comb begin
        span = IDX_W'((1 << mode) - 1);
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        // Purpose: mark lane start and point each slice at its lane's top slice.
        always_comb begin
            first_slice[i] = ((IDX_W'(i) & span) == '0);
            top_idx[i]     = IDX_W'(i) | span;
        end
    end

endmodule

// File: rtl/simd_carry_chain.sv
// Carry chain: adds the operands slice by slice. The carry into a slice
// that opens a lane is forced to zero, so lanes never exchange carries.
// Assumes DATA_W is a multiple of SLICE_W.
module simd_carry_chain #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W
)(
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic [NSLICE-1:0] first_slice,
    output logic [DATA_W-1:0] sum,
    output logic [NSLICE-1:0] cout
);

    logic [NSLICE-1:0] cin;

    for (genvar i = 0; i < NSLICE; i++) begin : g_slice
        if (i == 0) begin : g_lsb
            // Purpose: the lowest slice always starts a lane.
            always_comb cin[i] = 1'b0;
        end else begin : g_mid
            // Purpose: cut the carry at a lane boundary, pass it otherwise.
            always_comb cin[i] = first_slice[i] ? 1'b0 : cout[i-1];
        end

        // Purpose: one slice-wide ripple add with its carry out.
        always_comb begin
            {cout[i], sum[i*SLICE_W +: SLICE_W]} =
                {1'b0, a[i*SLICE_W +: SLICE_W]} +
                {1'b0, b[i*SLICE_W +: SLICE_W]} +
                {{SLICE_W{1'b0}}, cin[i]};
        end
    end

endmodule

// File: rtl/simd_sat_clamp.sv
// Saturation stage: detects overflow at each lane's top slice and, when
// saturation is enabled, replaces every slice of that lane by the clamp
// limit. It also spreads the lane's clamp flag over all its slices.
// Assumes top_idx comes from simd_lane_ctrl for the same lane mode.
module simd_sat_clamp #(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    localparam int NSLICE = DATA_W / SLICE_W,
    localparam int IDX_W  = $clog2(NSLICE)
)(
    input  logic [DATA_W-1:0]              a,
    input  logic [DATA_W-1:0]              b,
    input  logic [DATA_W-1:0]              raw_sum,
    input  logic [NSLICE-1:0]              cout,
    input  logic [NSLICE-1:0][IDX_W-1:0]   top_idx,
    input  logic                           sat_en,
    input  logic                           signed_en,
    output logic [DATA_W-1:0]              sum_out,
    output logic [NSLICE-1:0]              flags
);

    logic [NSLICE-1:0] a_msb;
    logic [NSLICE-1:0] b_msb;
    logic [NSLICE-1:0] s_msb;
    logic [NSLICE-1:0] ovf_u;
    logic [NSLICE-1:0] ovf_s;
    logic [NSLICE-1:0] clamp;
    logic [NSLICE-1:0] neg_lane;

    for (genvar j = 0; j < NSLICE; j++) begin : g_msb
        // Purpose: sign bits and both overflow kinds, as if slice j were a lane top.
        always_comb begin
            a_msb[j] = a[j*SLICE_W + SLICE_W - 1];
            b_msb[j] = b[j*SLICE_W + SLICE_W - 1];
            s_msb[j] = raw_sum[j*SLICE_W + SLICE_W - 1];
            ovf_u[j] = cout[j];
            ovf_s[j] = (a_msb[j] == b_msb[j]) && (s_msb[j] != a_msb[j]);
        end
    end

    for (genvar i = 0; i < NSLICE; i++) begin : g_out
        // Purpose: take the lane's overflow and sign from its top slice.
        always_comb begin
            clamp[i]    = sat_en && (signed_en ? ovf_s[top_idx[i]]
                                               : ovf_u[top_idx[i]]);
            neg_lane[i] = signed_en && a_msb[top_idx[i]];
            flags[i]    = clamp[i];
        end

        // Purpose: choose the clamp limit for this slice or keep the raw sum.
        always_comb begin
            if (!clamp[i]) begin
                sum_out[i*SLICE_W +: SLICE_W] = raw_sum[i*SLICE_W +: SLICE_W];
            end else if (!signed_en) begin
                sum_out[i*SLICE_W +: SLICE_W] = {SLICE_W{1'b1}};
            end else if (top_idx[i] == IDX_W'(i)) begin
                sum_out[i*SLICE_W +: SLICE_W] = neg_lane[i]
                    ? {1'b1, {(SLICE_W-1){1'b0}}}
                    : {1'b0, {(SLICE_W-1){1'b1}}};
            end else begin
                sum_out[i*SLICE_W +: SLICE_W] = neg_lane[i]
                    ? {SLICE_W{1'b0}} : {SLICE_W{1'b1}};
            end
        end
    end

endmodule

// File: rtl/simd_sat_adder.sv
// Top: partitioned SIMD adder with optional wrap or saturate per lane,
// signed or unsigned limits, and an optional output register.
// Assumes synchronous active-low reset; with REG_OUT = 0 clk and rst_n
// only clock the assertions.
module simd_sat_adder
    import simd_add_pkg::*;
#(
    parameter int DATA_W  = 64,
    parameter int SLICE_W = 8,
    parameter bit REG_OUT = 1'b1,
    localparam int NSLICE = DATA_W / SLICE_W,
    localparam int IDX_W  = $clog2(NSLICE)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [63:0]       op_a,
    input  logic [63:0]       op_b,
    input  logic [1:0]        lane_mode,
    input  logic              sat_en,
    input  logic              signed_en,
    output logic [63:0]       result,
    output logic [7:0]        sat_flags
);

    lane_mode_e                    mode;
    logic [NSLICE-1:0]             first_slice;
    logic [NSLICE-1:0][IDX_W-1:0]  top_idx;
    logic [DATA_W-1:0]             raw_sum;
    logic [NSLICE-1:0]             cout;
    logic [DATA_W-1:0]             comb_sum;
    logic [NSLICE-1:0]             comb_flags;

    // Purpose: decode the raw select into the lane mode type.
    always_comb mode = lane_mode_e'(lane_mode);

    simd_lane_ctrl #(.NSLICE(NSLICE)) u_ctrl (
        .mode        (mode),
        .first_slice (first_slice),
        .top_idx     (top_idx)
    );

    simd_carry_chain #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chain (
        .a           (op_a),
        .b           (op_b),
        .first_slice (first_slice),
        .sum         (raw_sum),
        .cout        (cout)
    );

    simd_sat_clamp #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_clamp (
        .a         (op_a),
        .b         (op_b),
        .raw_sum   (raw_sum),
        .cout      (cout),
        .top_idx   (top_idx),
        .sat_en    (sat_en),
        .signed_en (signed_en),
        .sum_out   (comb_sum),
        .flags     (comb_flags)
    );

    if (REG_OUT) begin : g_reg
        // Purpose: register result and flags, cleared by synchronous reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                result    <= '0;
                sat_flags <= '0;
            end else begin
                result    <= comb_sum;
                sat_flags <= comb_flags;
            end
        end

        // R8: outputs carry the previous cycle's combinational answer.
        a_r8_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |=> (result == $past(comb_sum)) &&
                             (sat_flags == $past(comb_flags)));
    end else begin : g_comb
        // Purpose: pass the combinational answer straight out.
        always_comb begin
            result    = comb_sum;
            sat_flags = comb_flags;
        end
    end

    // R2: in byte mode with wrapping, byte 1 ignores any carry from byte 0.
    a_r2_no_cross: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LANE_B8 && !sat_en) |->
            comb_sum[15:8] == 8'(op_a[15:8] + op_b[15:8]));

    // R6: wrapping mode never raises a flag.
    a_r6_wrap_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !sat_en |-> comb_flags == '0);

    // R6: a single 64-bit lane flags all bytes or none.
    a_r6_full_lane_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == LANE_B64) |-> (comb_flags == '0 || comb_flags == '1));

    // R4: a clamped unsigned lane shows all ones in its low byte.
    a_r4_unsigned_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && !signed_en && comb_flags[0]) |-> comb_sum[7:0] == 8'hFF);

    // R5: a clamped signed top lane keeps the operands' sign.
    a_r5_signed_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_en && signed_en && comb_flags[NSLICE-1]) |->
            comb_sum[DATA_W-1] == op_a[DATA_W-1]);

endmodule

// File: tb/tb_simd_sat_adder.sv
module tb_simd_sat_adder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] op_a, op_b;
    logic [1:0]  lane_mode;
    logic        sat_en, signed_en;
    logic [63:0] result;
    logic [7:0]  sat_flags;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    simd_sat_adder dut (
        .clk (clk), .rst_n (rst_n), .op_a (op_a), .op_b (op_b),
        .lane_mode (lane_mode), .sat_en (sat_en), .signed_en (signed_en),
        .result (result), .sat_flags (sat_flags)
    );

    // Watchdog: a hung run counts as one failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected below 100000", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Reference model written from the requirements, lane by lane.
    function automatic void ref_add(input logic [63:0] a, input logic [63:0] b,
                                    input logic [1:0] m, input bit s, input bit sg,
                                    output logic [63:0] r, output logic [7:0] f);
        int w;
        int n;
        logic [64:0] mask, x, y, t, v;
        bit ov, neg;
        w = 8 << m;
        n = 64 / w;
        r = '0;
        f = '0;
        mask = (65'd1 << w) - 65'd1;
        for (int l = 0; l < n; l++) begin
            x = ({1'b0, a} >> (l*w)) & mask;
            y = ({1'b0, b} >> (l*w)) & mask;
            t = x + y;
            v = t & mask;
            if (sg) begin
                neg = x[w-1];
                ov  = (x[w-1] == y[w-1]) && (t[w-1] != x[w-1]);
            end else begin
                neg = 1'b0;
                ov  = t[w];
            end
            if (s && ov) begin
                v = sg ? (neg ? (65'd1 << (w-1)) : (mask >> 1)) : mask;
                for (int k = 0; k < w/8; k++) f[l*(w/8) + k] = 1'b1;
            end
            r = r | 64'(v << (l*w));
        end
    endfunction

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    // Apply one vector at the falling edge, then check one edge later (R8 latency).
    task automatic run_vec(input string tag, input logic [63:0] a, input logic [63:0] b,
                           input logic [1:0] m, input bit s, input bit sg);
        logic [63:0] er;
        logic [7:0]  ef;
        @(negedge clk);
        op_a = a; op_b = b; lane_mode = m; sat_en = s; signed_en = sg;
        ref_add(a, b, m, s, sg, er, ef);
        @(posedge clk);
        #1;
        chk(tag, result, er);
        chk(tag, {56'd0, sat_flags}, {56'd0, ef});
    endtask

    function automatic logic [63:0] edge_word();
        logic [63:0] w;
        for (int k = 0; k < 8; k++) begin
            case ($urandom % 6)
                0: w[k*8 +: 8] = 8'h7F;
                1: w[k*8 +: 8] = 8'h80;
                2: w[k*8 +: 8] = 8'hFF;
                3: w[k*8 +: 8] = 8'h00;
                4: w[k*8 +: 8] = 8'h01;
                default: w[k*8 +: 8] = 8'($urandom);
            endcase
        end
        return w;
    endfunction

    initial begin
        logic [63:0] er;
        logic [7:0]  ef;
        void'($urandom(32'h1F2E3D4C));
        rst_n = 1'b0;
        op_a = 64'hFFFF_FFFF_FFFF_FFFF; op_b = 64'h0101_0101_0101_0101;
        lane_mode = 2'd0; sat_en = 1'b1; signed_en = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset result", result, 64'd0);
        chk("R1 reset flags", {56'd0, sat_flags}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: carries cut at every boundary width
        run_vec("R2 bytes wrap", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101, 2'd0, 0, 0);
        run_vec("R2 halves wrap", 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001, 2'd1, 0, 0);
        run_vec("R2 words wrap", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd2, 0, 0);
        run_vec("R2 full carry", 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 0, 0);
        // R3 and R9: signed select has no effect when wrapping
        run_vec("R3 wrap signed", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 1);
        run_vec("R9 wrap unsigned", 64'h7F7F_7F7F_7F7F_7F7F, 64'h0101_0101_0101_0101, 2'd0, 0, 0);
        // R4: unsigned clamp
        run_vec("R4 byte clamp", 64'hF0F0_F0F0_F0F0_F0F0, 64'h2020_2020_2020_2020, 2'd0, 1, 0);
        run_vec("R4 full clamp", 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0001, 2'd3, 1, 0);
        // R5: signed clamps both directions
        run_vec("R5 pos clamp", 64'h0000_0001_7FFF_FFFF, 64'h0000_0001_0000_0001, 2'd2, 1, 1);
        run_vec("R5 neg clamp", 64'h8000_8000_8000_8000, 64'hFFFF_FFFF_FFFF_FFFF, 2'd1, 1, 1);
        // R6: mixed lanes, flags only on the clamped lane
        run_vec("R6 mixed flags", 64'h1234_7FFF_0010_8000, 64'h0001_0001_0010_8000, 2'd1, 1, 1);
        // R7: no overflow in saturating mode
        run_vec("R7 no overflow", 64'h1122_3344_5566_7788, 64'h0101_0101_0101_0101, 2'd0, 1, 0);

        // R8: output holds until the next edge
        @(negedge clk);
        ref_add(op_a, op_b, lane_mode, sat_en, signed_en, er, ef);
        op_a = 64'h0; op_b = 64'h0;
        #1;
        chk("R8 hold before edge", result, er);
        @(posedge clk);
        #1;
        chk("R8 update after edge", result, 64'h0);

        // Random and boundary-biased vectors across all modes
        for (int i = 0; i < 800; i++) begin
            logic [63:0] a, b;
            logic [1:0] m;
            bit s, sg;
            a  = (i % 2 == 0) ? edge_word() : {$urandom, $urandom};
            b  = (i % 3 == 0) ? edge_word() : {$urandom, $urandom};
            m  = 2'($urandom);
            s  = 1'($urandom);
            sg = 1'($urandom);
            run_vec(s ? (sg ? "R5 random" : "R4 random") : "R3 random", a, b, m, s, sg);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule